// File: doc/BRIEF.md
# Recent Translation Latch Buffer

This block is a small, fully associative store of the most recent register rename translations. It sits beside the register alias table. Each entry holds an architectural register address and the physical register that was most recently allocated to it. When a rename lookup presents an architectural address, every entry compares against it in parallel. On a hit, the block raises a suppress signal in the same cycle so that the alias table does not sense its bitlines. The physical register then comes out of the buffer on the next clock edge, which is when a table read would have delivered it. On a miss, the table read goes ahead unchanged.

Entries are filled only when the renamer allocates a new physical register, in the same cycle as the table write. A lookup miss never pulls table data into the buffer. If the allocated architectural register is already held, its entry is rewritten in place. Otherwise an empty entry is taken if one exists, and if none does, a victim is picked by a free-running LFSR. An evicted entry is simply dropped. The table already holds the same mapping, so nothing is written back.

A source that the caller has already matched inside its own rename group is not served by the buffer. A flush empties every entry for misprediction recovery. Two counters let the hit ratio be measured. One counts lookups that the buffer served or could have served, and one counts hits. A chip uses one instance for integer registers and a separate instance for floating-point registers. The depth is 4 by default and must be a power of two, for example 8.

Top module: `rtlb_buffer`

## Requirements
- R1: Reset (synchronous, active high) empties every entry, clears `lkp_hit`, and zeroes both counters. Afterwards every lookup misses.
- R2: A lookup of an address held in the buffer raises `lkp_abort` combinationally in the same cycle. After the next rising edge, `lkp_hit` is 1 and `lkp_preg` is the physical register last allocated to that address. On a miss, `lkp_abort` is 0 and, after the edge, `lkp_hit` is 0.
- R3: An allocation whose architectural address is already held rewrites that entry in place. No other entry is lost, and at most one entry ever matches an address.
- R4: While empty entries remain, an allocation of a new address takes an empty entry. Allocating ENTRIES distinct addresses into an empty buffer therefore leaves all of them resident.
- R5: A lookup with `lkp_grp_match` high gives `lkp_abort` 0 and, after the edge, `lkp_hit` 0. It is not counted by either counter.
- R6: A lookup never changes the contents of the buffer. A missed address stays a miss until it is allocated.
- R7: An allocation of a new address into a full buffer replaces exactly one resident entry. The new address then hits with its new physical register.
- R8: `flush` empties every entry. An allocation in the same cycle as `flush` is discarded.
- R9: `lookup_count` rises by one for each lookup that has `lkp_grp_match` low. `hit_count` rises by one for each lookup that raised `lkp_abort`. Both counters wrap.
- R10: A lookup in the same cycle as an allocation sees the contents from before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all entries (misprediction recovery) |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_areg | input | AREG_W | Architectural address to look up |
| lkp_grp_match | input | 1 | Source already matched inside the rename group |
| alloc_valid | input | 1 | New physical register allocated this cycle |
| alloc_areg | input | AREG_W | Architectural address of the allocation |
| alloc_preg | input | PREG_W | Newly allocated physical register |
| lkp_abort | output | 1 | Same-cycle suppress for the alias table read |
| lkp_hit | output | 1 | Registered: the previous lookup hit |
| lkp_preg | output | PREG_W | Registered physical register for a hit |
| hit_count | output | CNT_W | Hits served |
| lookup_count | output | CNT_W | Lookups eligible for the buffer |

## Verification
The assertions assume that `alloc_valid` and `lkp_valid` stay low while `rst` is high. They also assume that the caller raises `lkp_grp_match` only together with `lkp_valid`. The bench keeps to both assumptions: it drives every request from tasks that start only after reset is released, and it pairs the group-match flag with a lookup every time. Victim choice depends on the LFSR and is not predicted. After an eviction, the bench instead probes every address and checks the invariants: the number of resident entries, the entry that must be present, and the correct physical register for any address that hits.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  // One step of an 8-bit maximal-length Fibonacci LFSR (x^8+x^6+x^5+x^4+1)
  function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb};
  endfunction
endpackage

// File: rtl/rtlb_lfsr.sv
module rtlb_lfsr #(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] state
);
  import rtlb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= lfsr8_next(state);
  end

  // An all-zero state would lock the sequence
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    state != 8'h00); // R7
endmodule

// File: rtl/rtlb_match.sv
module rtlb_match #(
  parameter int ENTRIES = 4,
  parameter int AREG_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][AREG_W-1:0] tags,
  input  logic [AREG_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (tags[i] == key);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/rtlb_victim.sv
module rtlb_victim #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [7:0]         rnd,
  output logic [IDX_W-1:0]   victim
);
  always_comb begin
    victim = rnd[IDX_W-1:0];
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) victim = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rtlb_buffer.sv
module rtlb_buffer #(
  parameter int         ENTRIES = 4,
  parameter int         AREG_W  = 5,
  parameter int         PREG_W  = 7,
  parameter int         CNT_W   = 16,
  parameter logic [7:0] SEED    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lkp_valid,
  input  logic [AREG_W-1:0] lkp_areg,
  input  logic              lkp_grp_match,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic [PREG_W-1:0] alloc_preg,
  output logic              lkp_abort,
  output logic              lkp_hit,
  output logic [PREG_W-1:0] lkp_preg,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  lookup_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][AREG_W-1:0] tag_q;
  logic [ENTRIES-1:0][PREG_W-1:0] map_q;
  logic [ENTRIES-1:0]             lk_vec, al_vec;
  logic [7:0]                     rnd;
  logic [IDX_W-1:0]               victim, al_idx, wr_idx;
  logic [PREG_W-1:0]              lk_preg;
  logic                           eligible;

  rtlb_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .state(rnd));

  rtlb_match #(.ENTRIES(ENTRIES), .AREG_W(AREG_W)) u_lk_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q),
    .key(lkp_areg), .hit_vec(lk_vec));

  rtlb_match #(.ENTRIES(ENTRIES), .AREG_W(AREG_W)) u_al_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q),
    .key(alloc_areg), .hit_vec(al_vec));

  rtlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .rnd(rnd), .victim(victim));

  // One-hot select of the resident mapping and of the in-place slot
  always_comb begin
    lk_preg = '0;
    al_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) lk_preg = lk_preg | map_q[i];
      if (al_vec[i]) al_idx  = IDX_W'(i);
    end
  end

  assign wr_idx    = (|al_vec) ? al_idx : victim;
  assign eligible  = lkp_valid && !lkp_grp_match;
  assign lkp_abort = eligible && (|lk_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q      <= '0;
      lkp_hit      <= 1'b0;
      lkp_preg     <= '0;
      hit_count    <= '0;
      lookup_count <= '0;
    end else begin
      lkp_hit  <= lkp_abort;
      lkp_preg <= lkp_abort ? lk_preg : '0;
      if (eligible)  lookup_count <= lookup_count + 1'b1;
      if (lkp_abort) hit_count    <= hit_count + 1'b1;
      if (flush)            valid_q         <= '0;
      else if (alloc_valid) valid_q[wr_idx] <= 1'b1;
    end
  end

  // Payload storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (alloc_valid && !flush) begin
      tag_q[wr_idx] <= alloc_areg;
      map_q[wr_idx] <= alloc_preg;
    end
  end

  AST_HIT_FOLLOWS_ABORT: assert property (@(posedge clk) disable iff (rst)
    lkp_hit |-> $past(lkp_abort)); // R2
  AST_GROUP_WINS: assert property (@(posedge clk) disable iff (rst)
    lkp_grp_match |-> !lkp_abort); // R5
  AST_LOOKUP_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    $past(!alloc_valid && !flush && !rst) |-> $stable(valid_q)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R8
  AST_ALLOC_RESIDENT: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !flush) |=> (valid_q != '0)); // R4
  AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && (hit_count != $past(hit_count)) |-> $past(lkp_abort)); // R9
endmodule

// File: tb/sim_rtlb_buffer.sv
module sim_rtlb_buffer;
  localparam int ENTRIES = 4;
  localparam int AREG_W  = 5;
  localparam int PREG_W  = 7;
  localparam int CNT_W   = 16;
  localparam int NAREG   = 1 << AREG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, lkp_valid = 1'b0, lkp_grp_match = 1'b0, alloc_valid = 1'b0;
  logic [AREG_W-1:0] lkp_areg = '0, alloc_areg = '0;
  logic [PREG_W-1:0] alloc_preg = '0;
  logic lkp_abort, lkp_hit;
  logic [PREG_W-1:0] lkp_preg;
  logic [CNT_W-1:0] hit_count, lookup_count;

  int checks = 0, errors = 0;
  int exp_looks = 0, obs_hits = 0;
  int last_p [NAREG];
  logic got_hit;
  logic [PREG_W-1:0] got_preg;

  always #5 clk = ~clk;

  rtlb_buffer #(.ENTRIES(ENTRIES), .AREG_W(AREG_W), .PREG_W(PREG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .lkp_valid(lkp_valid), .lkp_areg(lkp_areg),
    .lkp_grp_match(lkp_grp_match), .alloc_valid(alloc_valid), .alloc_areg(alloc_areg),
    .alloc_preg(alloc_preg), .lkp_abort(lkp_abort), .lkp_hit(lkp_hit), .lkp_preg(lkp_preg),
    .hit_count(hit_count), .lookup_count(lookup_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at posedge+1; returns at posedge+1 with registered result
  task automatic lookup(input int a, input logic g, input logic do_alloc, input int p);
    logic ab;
    lkp_valid = 1'b1; lkp_areg = AREG_W'(a); lkp_grp_match = g;
    alloc_valid = do_alloc; alloc_areg = AREG_W'(a); alloc_preg = PREG_W'(p);
    #1 ab = lkp_abort;
    @(posedge clk); #1;
    lkp_valid = 1'b0; lkp_grp_match = 1'b0; alloc_valid = 1'b0;
    got_hit = lkp_hit; got_preg = lkp_preg;
    if (do_alloc) last_p[a] = p;
    if (!g) exp_looks++;
    if (got_hit) obs_hits++;
    checks++;
    if (ab != got_hit) begin
      errors++;
      $display("FAIL R2 abort/hit mismatch actual=%0d expected=%0d", got_hit, ab);
    end
  endtask

  task automatic alloc(input int a, input int p, input logic fl);
    alloc_valid = 1'b1; alloc_areg = AREG_W'(a); alloc_preg = PREG_W'(p); flush = fl;
    @(posedge clk); #1;
    alloc_valid = 1'b0; flush = 1'b0;
    if (!fl) last_p[a] = p;
  endtask

  // Probe every address; count hits and check mappings of hits
  task automatic sweep(output int nhit);
    nhit = 0;
    for (int a = 0; a < NAREG; a++) begin
      lookup(a, 1'b0, 1'b0, 0);
      if (got_hit) begin
        nhit++;
        chk("R2 hit preg", int'(got_preg), last_p[a]);
      end
    end
  endtask

  initial begin
    int n;
    for (int a = 0; a < NAREG; a++) last_p[a] = -1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 lkp_hit", int'(lkp_hit), 0);
    chk("R1 hit_count", int'(hit_count), 0);
    chk("R1 lookup_count", int'(lookup_count), 0);
    sweep(n);
    chk("R1 empty sweep hits", n, 0);
    // R6 misses did not fill anything
    sweep(n);
    chk("R6 no fill on miss", n, 0);
    // R4 fill empty entries
    for (int a = 0; a < ENTRIES; a++) alloc(a, 40 + a, 1'b0);
    sweep(n);
    chk("R4 all resident", n, ENTRIES);
    for (int a = 0; a < ENTRIES; a++) begin
      lookup(a, 1'b0, 1'b0, 0);
      chk("R4 resident hit", int'(got_hit), 1);
    end
    // R3 in-place update
    alloc(2, 77, 1'b0);
    lookup(2, 1'b0, 1'b0, 0);
    chk("R3 updated preg", int'(got_preg), 77);
    sweep(n);
    chk("R3 no entry lost", n, ENTRIES);
    // R5 group match wins
    lkp_valid = 1'b1; lkp_areg = 1; lkp_grp_match = 1'b1;
    #1 chk("R5 abort low", int'(lkp_abort), 0);
    lkp_valid = 1'b0; lkp_grp_match = 1'b0;
    lookup(1, 1'b1, 1'b0, 0);
    chk("R5 no hit", int'(got_hit), 0);
    // R10 lookup sees pre-allocation contents
    lookup(9, 1'b0, 1'b1, 55);
    chk("R10 old contents", int'(got_hit), 0);
    lookup(9, 1'b0, 1'b0, 0);
    chk("R7 new entry hits", int'(got_hit), 1);
    chk("R7 new entry preg", int'(got_preg), 55);
    sweep(n);
    chk("R7 one evicted", n, ENTRIES);
    // R7 repeated evictions
    for (int k = 0; k < 12; k++) begin
      alloc(10 + k, 90 + k, 1'b0);
      lookup(10 + k, 1'b0, 1'b0, 0);
      chk("R7 new entry hits", int'(got_hit), 1);
      sweep(n);
      chk("R7 resident count", n, ENTRIES);
    end
    // R8 flush
    @(posedge clk); #1;
    flush = 1'b1; @(posedge clk); #1; flush = 1'b0;
    sweep(n);
    chk("R8 flushed", n, 0);
    alloc(5, 33, 1'b1);
    lookup(5, 1'b0, 1'b0, 0);
    chk("R8 alloc dropped with flush", int'(got_hit), 0);
    // R9 counters
    chk("R9 lookup_count", int'(lookup_count), exp_looks);
    chk("R9 hit_count", int'(hit_count), obs_hits);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule